// File: doc/BRIEF.md
# Multiplexed Band Sequencer Timing Controller

This block is the digital timing core of a time-shared five-band filter front end. From one master clock it steps a band index through five bands in a fixed circular order. Each band is held for a programmable dwell period. A read strobe fires a fixed number of cycles before every band change, so that an external converter can sample the shared output while the band is still settled. A one-hot filter select follows the active band and drives the filter-constant switching.

The external reset is active low and arrives on a pin that is shared with the divided clock output. The pin is synchronized, and its low width is qualified, so that short glitches are ignored. Once a valid pulse ends, the sequence restarts at the first band after a fixed latency. A divided clock runs at two thirds of the master rate, produced as a 1,1,0 clock-enable pattern, and can feed a second unit. A second unit runs in slave mode, where every interval is stretched by 3/2. The mode is captured while the synchronous chip reset is high.

Top module: `band_seq_timer`

## Requirements
- R1: While running, `band_idx` takes the values 0,1,2,3,4 (0 is the first band) in that order and then wraps to 0. Each value is held for D cycles, where D is DWELL in master mode and DWELL*3/2 in slave mode.
- R2: `filt_sel` has bit k set, and only that bit, while `band_idx` is k and the sequence is running. It is all zero otherwise.
- R3: `rd_stb` rises exactly L cycles before each band change, where L is 248 in master mode and 372 in slave mode.
- R4: `rd_stb` stays high for 8 cycles in master mode and 12 cycles in slave mode, once per band period.
- R5: A low level on `rst_clk_n` counts as a reset only if it is sampled low on at least M consecutive rising edges, where M is 4 in master mode and 6 in slave mode. A shorter pulse leaves the band sequence and strobe timing unchanged.
- R6: After a qualified low has lasted M+2 cycles, and until it ends, `filt_sel` and `rd_stb` are zero.
- R7: After a qualified low pulse, let E0 be the first rising edge that samples `rst_clk_n` high. `filt_sel` becomes 5'b00001 right after edge E0+52 in master mode (E0+78 in slave mode) and is zero just before that edge.
- R8: `clk23_out` is high after edge k when `rst_clk_n` was sampled high at edge k-2, and low when it was sampled low at edge k-2. During each run of high samples it follows the repeating pattern 1,1,0, starting at 1.
- R9: While `rst` is high, all outputs are zero and `slave_mode` is captured. The first band becomes active right after the 52nd (slave: 78th) rising edge following the release of `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high chip reset |
| slave_mode | input | 1 | 1 selects slave timing (intervals times 3/2); captured during `rst` |
| rst_clk_n | input | 1 | Active-low external reset level from the shared pin |
| band_idx | output | 3 | Active band, 0 to 4 |
| filt_sel | output | 5 | One-hot filter-constant select |
| rd_stb | output | 1 | Read strobe ahead of each band change |
| clk23_out | output | 1 | Two-thirds-rate clock-enable pattern, held low during reset |

## Verification
The pin passes through two synchronizer flops, so the clock output reacts two edges after the pin is sampled. Release is decided one edge later again, which puts the first band exactly 52 or 78 edges after the first high sample. The bench counts edges from the exact edge at which it drives each stimulus. It places the latency checks one edge before and one edge after the due edge. During the runs it compares every cycle against a band position computed from the time since the first band started, so strobe lead, strobe width and dwell are all checked against their edge.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int NBANDS = 5;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef logic [IDX_W-1:0] band_idx_t;

    typedef struct packed {
        band_idx_t         idx;
        logic [NBANDS-1:0] sel;
        logic              strobe;
    } band_view_t;

    // Slave timing stretches every interval by 3/2.
    function automatic int unsigned stretch(input int unsigned base, input logic slave);
        return slave ? base + base / 2 : base;
    endfunction

    function automatic band_idx_t next_band(input band_idx_t b);
        return (b == band_idx_t'(NBANDS - 1)) ? '0 : b + 1'b1;
    endfunction

    function automatic logic [NBANDS-1:0] sel_of(input band_idx_t b);
        logic [NBANDS-1:0] s;
        for (int i = 0; i < NBANDS; i++) s[i] = (b == band_idx_t'(i));
        return s;
    endfunction

endpackage

// File: rtl/bsq_rst_qual.sv
module bsq_rst_qual #(
    parameter int MINW = 4,
    localparam int QW  = $clog2(MINW + MINW / 2 + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic slave,
    input  logic pin_n,
    output logic pin_hi,
    output logic rel_o,
    output logic hold_o
);
    import bsq_pkg::*;

    logic          s1;
    logic          s2;
    logic [QW-1:0] cnt;
    logic [QW-1:0] minw_c;

    assign minw_c = QW'(stretch(MINW, slave));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            cnt <= '0;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            if (!s2) cnt <= (cnt >= minw_c) ? cnt : cnt + 1'b1;
            else     cnt <= '0;
        end
    end

    assign pin_hi = s2;
    assign rel_o  = s2 && (cnt >= minw_c);
    assign hold_o = !s2 && (cnt >= minw_c);

    p_release_after_low_r5: assert property (@(posedge clk) disable iff (rst)
        rel_o |-> !$past(pin_hi));
    p_width_saturates_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= minw_c);
endmodule

// File: rtl/bsq_clk_div23.sv
module bsq_clk_div23 (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic clk_out
);
    logic [1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph      <= '0;
            clk_out <= 1'b0;
        end else begin
            clk_out <= (ph != 2'd2);
            ph      <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        end
    end

    p_stopped_low_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !clk_out);
    p_no_three_high_r8: assert property (@(posedge clk) disable iff (rst)
        (clk_out && $past(clk_out)) |=> !clk_out);
endmodule

// File: rtl/bsq_band_seq.sv
module bsq_band_seq #(
    parameter int DWELL = 2048,
    parameter int LEAD  = 248,
    parameter int WIDTH = 8,
    parameter int LAT   = 52,
    localparam int CW   = $clog2(DWELL + DWELL / 2 + 1),
    localparam int LW   = $clog2(LAT + LAT / 2 + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slave,
    input  logic                rel_i,
    input  logic                hold_i,
    output bsq_pkg::band_view_t view_o
);
    import bsq_pkg::*;

    seq_state_e    state;
    logic [LW-1:0] wc;
    logic [CW-1:0] dc;
    logic [CW-1:0] dc_n;
    band_idx_t     band_n;
    band_view_t    view;
    logic [CW-1:0] dwell_c;
    logic [CW-1:0] lo_c;
    logic [CW-1:0] hi_c;
    logic [LW-1:0] lat_c;
    logic          wrap;

    assign dwell_c = CW'(stretch(DWELL, slave));
    assign lo_c    = dwell_c - CW'(stretch(LEAD, slave));
    assign hi_c    = lo_c + CW'(stretch(WIDTH, slave));
    assign lat_c   = LW'(stretch(LAT, slave));

    always_comb begin
        wrap   = (dc == dwell_c - 1'b1);
        dc_n   = wrap ? '0 : dc + 1'b1;
        band_n = wrap ? next_band(view.idx) : view.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT;
            wc    <= lat_c - LW'(1);
            dc    <= '0;
            view  <= '0;
        end else if (rel_i) begin
            state <= ST_WAIT;
            wc    <= lat_c - LW'(3);
            dc    <= '0;
            view  <= '0;
        end else if (hold_i) begin
            state <= ST_HOLD;
            dc    <= '0;
            view  <= '0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (wc == '0) begin
                        state       <= ST_RUN;
                        dc          <= '0;
                        view.idx    <= '0;
                        view.sel    <= sel_of('0);
                        view.strobe <= 1'b0;
                    end else begin
                        wc <= wc - 1'b1;
                    end
                end
                ST_RUN: begin
                    dc          <= dc_n;
                    view.idx    <= band_n;
                    view.sel    <= sel_of(band_n);
                    view.strobe <= (dc_n >= lo_c) && (dc_n < hi_c);
                end
                default: ;
            endcase
        end
    end

    assign view_o = view;

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(view.sel));
    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> (view.sel == '0 && !view.strobe));
    p_band_order_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN && view.idx != $past(view.idx))
        |-> (view.idx == next_band($past(view.idx))));
    p_strobe_min_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(view.strobe) |=> view.strobe);
endmodule

// File: rtl/band_seq_timer.sv
module band_seq_timer #(
    parameter int DWELL      = 2048,
    parameter int LEAD_CYC   = 248,
    parameter int WIDTH_CYC  = 8,
    parameter int MINW_CYC   = 4,
    parameter int LAT_CYC    = 52
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slave_mode,
    input  logic       rst_clk_n,
    output logic [2:0] band_idx,
    output logic [4:0] filt_sel,
    output logic       rd_stb,
    output logic       clk23_out
);
    import bsq_pkg::*;

    logic       mode_q;
    logic       mode_eff;
    logic       pin_hi;
    logic       rel;
    logic       hold;
    band_view_t view;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= slave_mode;
    end

    assign mode_eff = rst ? slave_mode : mode_q;

    bsq_rst_qual #(.MINW(MINW_CYC)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .slave  (mode_eff),
        .pin_n  (rst_clk_n),
        .pin_hi (pin_hi),
        .rel_o  (rel),
        .hold_o (hold)
    );

    bsq_clk_div23 u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (pin_hi),
        .clk_out (clk23_out)
    );

    bsq_band_seq #(
        .DWELL (DWELL),
        .LEAD  (LEAD_CYC),
        .WIDTH (WIDTH_CYC),
        .LAT   (LAT_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .slave  (mode_eff),
        .rel_i  (rel),
        .hold_i (hold),
        .view_o (view)
    );

    assign band_idx = view.idx;
    assign filt_sel = view.sel;
    assign rd_stb   = view.strobe;

    initial begin
        assert (DWELL > LEAD_CYC + WIDTH_CYC && DWELL % 2 == 0)
            else $error("dwell too short or odd");
    end
endmodule

// File: tb/band_seq_timer_tb.sv
`timescale 1ns/1ps
module band_seq_timer_tb;
    localparam int DW = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slave_mode = 1'b0;
    logic       rst_clk_n = 1'b1;
    logic [2:0] band_idx;
    logic [4:0] filt_sel;
    logic       rd_stb;
    logic       clk23_out;

    always #2 clk = ~clk;

    band_seq_timer #(.DWELL(DW)) u_dut (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .rst_clk_n(rst_clk_n),
        .band_idx(band_idx), .filt_sel(filt_sel), .rd_stb(rd_stb), .clk23_out(clk23_out)
    );

    int checks = 0;
    int fails  = 0;
    int d_len = DW, lead = 248, wid = 8;
    bit mrun = 0, chk_band = 0;
    int t = 0;
    bit bd1 = 1, bd2 = 1, ben = 0;
    int bph = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock edge; model of the divided clock and band position advanced at the edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            bd1 = 1; bd2 = 1; bph = 0; ben = 0;
        end else begin
            ben = bd2 ? (bph != 2) : 1'b0;
            bph = bd2 ? ((bph == 2) ? 0 : bph + 1) : 0;
            bd2 = bd1;
            bd1 = rst_clk_n;
        end
        if (mrun) t++;
        @(negedge clk);
        chk(clk23_out == ben, "R8 clk23", clk23_out, ben);
        if (chk_band) begin
            int pos = t % d_len;
            int eb  = (t / d_len) % 5;
            bit es  = (pos >= d_len - lead) && (pos < d_len - lead + wid);
            chk(band_idx == eb, "R1 band", band_idx, eb);
            chk(filt_sel == (5'b1 << eb), "R2 sel", filt_sel, 1 << eb);
            if (pos == d_len - lead || pos == d_len - lead - 1)
                chk(rd_stb == es, "R3 strobe lead", rd_stb, es);
            else
                chk(rd_stb == es, "R4 strobe width", rd_stb, es);
        end
    endtask

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chip_reset(input bit mode, input int lat);
        chk_band = 0; mrun = 0;
        slave_mode = mode;
        d_len = mode ? DW * 3 / 2 : DW;
        lead  = mode ? 372 : 248;
        wid   = mode ? 12 : 8;
        rst = 1;
        sweep(3);
        chk(filt_sel == 0 && band_idx == 0, "R9 reset sel", filt_sel, 0);
        chk(rd_stb == 0 && clk23_out == 0, "R9 reset stb", rd_stb, 0);
        rst = 0;
        sweep(lat - 1);
        chk(filt_sel == 0, "R9 before latency", filt_sel, 0);
        sweep(1);
        chk(filt_sel == 5'b00001, "R9 at latency", filt_sel, 1);
        mrun = 1; t = 0; chk_band = 1;
    endtask

    task automatic short_pulse(input int n);
        rst_clk_n = 0;
        sweep(n);
        rst_clk_n = 1;
    endtask

    task automatic valid_pulse(input int n, input int minw, input int lat);
        chk_band = 0; mrun = 0;
        rst_clk_n = 0;
        sweep(n);
        if (n >= minw + 3) begin
            chk(filt_sel == 0, "R6 sel quiet", filt_sel, 0);
            chk(rd_stb == 0, "R6 strobe quiet", rd_stb, 0);
        end
        rst_clk_n = 1;
        sweep(lat);
        chk(filt_sel == 0, "R7 before latency", filt_sel, 0);
        sweep(1);
        chk(filt_sel == 5'b00001 && band_idx == 0, "R7 first band", filt_sel, 1);
        mrun = 1; t = 0; chk_band = 1;
    endtask

    initial begin
        @(negedge clk);
        // master timing
        chip_reset(1'b0, 52);
        sweep(2 * 5 * DW + 50);
        short_pulse(3);            // R5: below the 4-cycle minimum
        sweep(500);
        valid_pulse(4, 4, 52);     // R5 boundary: exactly the minimum
        sweep(1000);
        valid_pulse(10, 4, 52);
        sweep(2100);
        // slave timing
        chip_reset(1'b1, 78);
        sweep(5 * DW * 3 / 2 + 100);
        short_pulse(5);            // R5: below the 6-cycle minimum
        sweep(700);
        valid_pulse(6, 6, 78);
        sweep(700);
        valid_pulse(12, 6, 78);
        sweep(3100);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule